// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends pairs of 18-bit two's complement audio samples, one left and one right, out on a single serial data line. The two words of a pair were captured at the same instant. The line is framed by a bit clock and a frame clock. Each frame holds 64 bit slots. The left word fills one half of the frame clock period and the right word fills the other. Every word goes out MSB first, and zeros pad the rest of its half.

The block runs in one of two clock roles. As clock master it divides its master clock by 4 to make the bit clock and by 256 to make the frame clock, and drives both out. As clock slave it takes both clocks as inputs and passes them through two-flop synchronizers in the master clock domain. It then follows their edges. A static select picks one of two framings:

- **Left-justified:** the MSB goes out with the frame clock edge, and a high frame clock marks the left half.
- **I2S-compatible:** the MSB goes out one bit slot after the frame clock edge, and a low frame clock marks the left half.

A producer offers a pair with a one-cycle valid strobe. The pair waits in a pending register and moves into a holding register when the next frame starts. A pair that arrives mid-frame therefore cannot disturb the words being sent.

Top module: `stereo_ser_tx`

## Requirements
- R1: In master mode `sclk_o` is the master clock divided by 4. It is low for 2 cycles and then high for 2 cycles, starting low after reset.
- R2: In master mode `lrck_o` is the master clock divided by 256, and it only changes together with a falling `sclk_o`. The first 128 cycles after reset form the left half. `lrck_o` is 1 during the left half in left-justified format (`fmt_i2s_i`=0) and 0 during the left half in I2S format (`fmt_i2s_i`=1).
- R3: Each 18-bit word is sent MSB first, the left word in the left half and the right word in the right half. Every slot after the word's last bit in a half carries 0.
- R4: In left-justified format, bit 17 of the word sits in slot 0 of its half and bit 17-k sits in slot k, for k from 0 to 17.
- R5: In I2S format, slot 0 of each half carries 0 and bit 18-k sits in slot k, for k from 1 to 18.
- R6: In master mode `sdata_o` changes only in cycles where `sclk_o` falls, so it is stable at every rising `sclk_o`.
- R7: On the cycle that starts a frame (the left-half start), both words are loaded from the pair given that cycle. If no pair is given that cycle, they are loaded from the latest earlier pair. A pair given at any other time does not change the frame being sent.
- R8: In slave mode `sclk_o` and `lrck_o` are held at 0. Each frame clock edge seen after synchronization resets the slot count of the new half to 0. Each synchronized falling bit clock edge then advances it by one, and a frame begins at the edge into the left half.
- R9: In slave mode with a bit clock of 32 times the frame rate, each half has 16 slots and carries bits 17 down to 2 of its word (left-justified format).
- R10: While reset is active, `sdata_o` and `sclk_o` are 0, and `lrck_o` equals 1 only in master mode with left-justified format. The holding register clears to zero, so the first frame after reset carries zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Clock role: 1 = master, 0 = slave (static) |
| fmt_i2s_i | input | 1 | Framing: 0 = left-justified, 1 = I2S-compatible (static) |
| pair_valid_i | input | 1 | One-cycle strobe offering a sample pair |
| left_i | input | 18 | Left sample, two's complement |
| right_i | input | 18 | Right sample, two's complement |
| sclk_i | input | 1 | Bit clock in slave mode |
| lrck_i | input | 1 | Frame clock in slave mode |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Bit clock in master mode, 0 in slave mode |
| lrck_o | output | 1 | Frame clock in master mode, 0 in slave mode |

## Verification
The bench builds the block with its default parameters: 18-bit words, 64-slot frames and a divide-by-4 bit clock. With these values a whole master frame lasts 256 cycles, so several frames in both framings fit in a short run. Pair strobes in those runs land mid-frame, on the cycle that starts a frame, and on the cycle just before it.

The slave runs use a bench-made bit clock of 12 master clocks per slot. This leaves room for the synchronizer latency. The 64-slot and 32-slot variants reach both the full word with padding and the truncated 16-slot half.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } fmt_e;

  // slots of delay between frame clock edge and MSB
  function automatic int lead_slots(fmt_e f);
    return (f == FMT_I2S) ? 1 : 0;
  endfunction

endpackage

// File: rtl/stx_bit_sel.sv
module stx_bit_sel
  import stx_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int SLOT_W = 5
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  fmt_e              fmt_i,
  output logic              bit_o
);

  always_comb begin
    int d;
    d     = int'(slot_i) - lead_slots(fmt_i);
    bit_o = 1'b0;
    if (d >= 0 && d < WORD_W) bit_o = word_i[WORD_W-1-d];
  end

endmodule

// File: rtl/stx_mclk_div.sv
module stx_mclk_div #(
  parameter int DIV        = 4,
  parameter int FRAME_BITS = 64,
  localparam int DIV_W     = $clog2(DIV),
  localparam int CNT_W     = $clog2(DIV * FRAME_BITS),
  localparam int SLOT_W    = CNT_W - 1 - DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              i2s_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              left_o,
  output logic              frame_start_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  assign sclk_o        = en_i & cnt_q[DIV_W-1];
  // left half is the first half of the count; polarity flips for I2S
  assign lrck_o        = en_i & (cnt_q[CNT_W-1] ~^ i2s_i);
  assign slot_o        = cnt_q[CNT_W-2:DIV_W];
  assign left_o        = ~cnt_q[CNT_W-1];
  assign frame_start_o = en_i & (&cnt_q);

  // R1
  sclk_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && $rose(sclk_o) |=> sclk_o);
  // R1
  sclk_low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && $fell(sclk_o) |=> !sclk_o);
  // R2
  lrck_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && !$stable(lrck_o) |-> $fell(sclk_o));

endmodule

// File: rtl/stx_slave_trk.sv
module stx_slave_trk #(
  parameter int SLOT_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              i2s_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              left_o,
  output logic              frame_start_o
);

  // SYNC_N synchronizer flops plus one history flop for edge detection
  logic [SYNC_N:0] sclk_sh_q, lrck_sh_q;
  logic            lr_edge, sc_fall, new_left;
  logic [SLOT_W-1:0] slot_q;
  logic            left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sh_q <= '0;
      lrck_sh_q <= '0;
    end else begin
      sclk_sh_q <= {sclk_sh_q[SYNC_N-1:0], sclk_i};
      lrck_sh_q <= {lrck_sh_q[SYNC_N-1:0], lrck_i};
    end
  end

  assign lr_edge  = lrck_sh_q[SYNC_N-1] ^ lrck_sh_q[SYNC_N];
  assign sc_fall  = ~sclk_sh_q[SYNC_N-1] & sclk_sh_q[SYNC_N];
  assign new_left = lrck_sh_q[SYNC_N-1] ^ i2s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      left_q <= 1'b0;
    end else if (!en_i) begin
      slot_q <= '0;
      left_q <= 1'b0;
    end else if (lr_edge) begin
      slot_q <= '0;
      left_q <= new_left;
    end else if (sc_fall && !(&slot_q)) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o        = slot_q;
  assign left_o        = left_q;
  assign frame_start_o = en_i & lr_edge & new_left;

  // R8
  slot_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && lr_edge |=> slot_o == '0);
  // R8
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) && !$stable(slot_o) |->
      (slot_o == '0 || slot_o == SLOT_W'($past(slot_o) + 1'b1)));

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stx_pkg::*;
#(
  parameter int WORD_W     = 18,
  parameter int FRAME_BITS = 64,
  parameter int MCLK_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              fmt_i2s_i,
  input  logic              pair_valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              lrck_o
);

  localparam int SLOT_W = $clog2(FRAME_BITS / 2);

  logic [SLOT_W-1:0] m_slot, s_slot, slot;
  logic              m_left, s_left, in_left;
  logic              m_fs, s_fs, frame_start;
  logic [WORD_W-1:0] pend_l_q, pend_r_q, hold_l_q, hold_r_q, cur_word;

  stx_mclk_div #(.DIV(MCLK_DIV), .FRAME_BITS(FRAME_BITS)) u_div (
    .clk_i, .rst_ni, .en_i(master_i), .i2s_i(fmt_i2s_i),
    .sclk_o, .lrck_o, .slot_o(m_slot), .left_o(m_left), .frame_start_o(m_fs)
  );

  stx_slave_trk #(.SLOT_W(SLOT_W), .SYNC_N(2)) u_trk (
    .clk_i, .rst_ni, .en_i(~master_i), .i2s_i(fmt_i2s_i),
    .sclk_i, .lrck_i, .slot_o(s_slot), .left_o(s_left), .frame_start_o(s_fs)
  );

  assign slot        = master_i ? m_slot : s_slot;
  assign in_left     = master_i ? m_left : s_left;
  assign frame_start = master_i ? m_fs   : s_fs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else begin
      if (pair_valid_i) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
      end
      if (frame_start) begin
        hold_l_q <= pair_valid_i ? left_i  : pend_l_q;
        hold_r_q <= pair_valid_i ? right_i : pend_r_q;
      end
    end
  end

  assign cur_word = in_left ? hold_l_q : hold_r_q;

  stx_bit_sel #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_sel (
    .word_i(cur_word), .slot_i(slot), .fmt_i(fmt_e'(fmt_i2s_i)), .bit_o(sdata_o)
  );

  // R6
  data_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && !$fell(sclk_o) |-> $stable(sdata_o));
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(hold_l_q) && $stable(hold_r_q));
  // R3
  pad_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(slot) > WORD_W |-> !sdata_o);
  // R5
  i2s_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i2s_i && slot == '0 |-> !sdata_o);
  // R8
  slave_clk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sclk_o && !lrck_o);

endmodule

// File: tb/stereo_ser_tx_tb_top.sv
module stereo_ser_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SL_HALF    = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        master = 1'b1, fmt = 1'b0, valid = 1'b0;
  logic [17:0] l_in = '0, r_in = '0;
  logic        sclk_in = 1'b0, lrck_in = 1'b0;
  logic        sdata, sclk_out, lrck_out;

  int total = 0, bad = 0;
  bit mchk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_ser_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .fmt_i2s_i(fmt),
    .pair_valid_i(valid), .left_i(l_in), .right_i(r_in),
    .sclk_i(sclk_in), .lrck_i(lrck_in),
    .sdata_o(sdata), .sclk_o(sclk_out), .lrck_o(lrck_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input logic [17:0] w, input int slot, input bit i2s);
    int d;
    d = slot - (i2s ? 1 : 0);
    return (d >= 0 && d < 18) ? w[17-d] : 1'b0;
  endfunction

  // master-mode reference: mclk count, pending and held pair
  int          m_cnt;
  logic [17:0] hl, hr, pl, pr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; hl = '0; hr = '0; pl = '0; pr = '0;
    end else if (master) begin
      if (m_cnt == 255) begin
        hl = valid ? l_in : pl;
        hr = valid ? r_in : pr;
      end
      if (valid) begin pl = l_in; pr = r_in; end
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mchk) begin
      bit          e_sclk, e_lrck, e_dat, lft;
      logic [17:0] w;
      lft    = (m_cnt < 128);
      e_sclk = ((m_cnt / 2) % 2) == 1;
      e_lrck = fmt ? !lft : lft;
      w      = lft ? hl : hr;
      e_dat  = exp_bit(w, (m_cnt / 4) % 32, fmt);
      chk(sclk_out == e_sclk, "R1", "sclk_o", int'(sclk_out), int'(e_sclk));
      chk(lrck_out == e_lrck, "R2", "lrck_o", int'(lrck_out), int'(e_lrck));
      if (fmt) chk(sdata == e_dat, "R3 R5 R6 R7", "sdata_o", int'(sdata), int'(e_dat));
      else     chk(sdata == e_dat, "R3 R4 R6 R7", "sdata_o", int'(sdata), int'(e_dat));
    end
  end

  task automatic do_reset(input bit m, input bit f, input bit lr0);
    @(negedge clk);
    rst_n = 1'b0; master = m; fmt = f; lrck_in = lr0; sclk_in = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    chk(sdata == 1'b0, "R10", "reset sdata_o", int'(sdata), 0);
    chk(sclk_out == 1'b0, "R10", "reset sclk_o", int'(sclk_out), 0);
    chk(lrck_out == (m && !f), "R10", "reset lrck_o", int'(lrck_out), int'(m && !f));
    rst_n = 1'b1;
  endtask

  task automatic run_master(input bit f);
    do_reset(1'b1, f, 1'b0);
    mchk = 1'b1;
    for (int n = 0; n < 4 * 256; n++) begin
      @(negedge clk);
      valid = 1'b0;
      if (n == 40)  begin valid = 1'b1; l_in = 18'h20000; r_in = 18'h1FFFF; end
      if (n == 254) begin valid = 1'b1; l_in = 18'h2AAAA; r_in = 18'h15555; end
      if (n == 255) begin valid = 1'b1; l_in = 18'h3FFFF; r_in = 18'h00001; end
      if (n == 300) begin valid = 1'b1; l_in = 18'h12345; r_in = 18'h2F0F0; end
      if (n == 510) begin valid = 1'b1; l_in = 18'h0F00F; r_in = 18'h3C3C3; end
      if (n == 700) begin valid = 1'b1; l_in = 18'h30001; r_in = 18'h20001; end
    end
    @(negedge clk);
    mchk = 1'b0;
    valid = 1'b0;
  endtask

  task automatic run_slave(input bit i2s, input int half, input int nfr);
    logic [17:0] cl, cr;
    do_reset(1'b0, i2s, i2s);
    for (int f = 0; f < nfr; f++) begin
      cl = 18'h2B3C5 ^ 18'(f * 18'h0713F);
      cr = 18'h1C0DE ^ 18'(f * 18'h2A5A1);
      @(negedge clk);
      valid = 1'b1; l_in = cl; r_in = cr;
      @(negedge clk);
      valid = 1'b0;
      for (int b = 0; b < 2 * half; b++) begin
        bit e;
        sclk_in = 1'b0;
        if (b == 0)    lrck_in = !i2s;
        if (b == half) lrck_in = i2s;
        if (b == 5) begin valid = 1'b1; l_in = ~cl; r_in = ~cr; end
        repeat (SL_HALF) begin @(negedge clk); valid = 1'b0; end
        e = exp_bit((b < half) ? cl : cr, b % half, i2s);
        if (half == 16) chk(sdata == e, "R9", "slave 32x sdata_o", int'(sdata), int'(e));
        else            chk(sdata == e, "R8", "slave sdata_o", int'(sdata), int'(e));
        chk(sclk_out == 1'b0 && lrck_out == 1'b0, "R8", "slave clk outs",
            int'({sclk_out, lrck_out}), 0);
        sclk_in = 1'b1;
        repeat (SL_HALF) @(negedge clk);
      end
    end
  endtask

  initial begin
    run_master(1'b0);
    run_master(1'b1);
    run_slave(1'b0, 32, 2);
    run_slave(1'b1, 32, 2);
    run_slave(1'b0, 16, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule